// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output compare channel. It watches the count of an external free-running timer and drives a single output pin. A 3-bit mode code sets the behaviour: set the pin high once, set it low once, toggle it on every match, or produce one pulse framed by two compare values. Writing a mode code puts the pin at a level that depends on the mode, and it re-arms the one-shot behaviours. The timer does not have to be stopped or cleared for this.

Two timer count buses feed the channel, and a select bit picks which one is compared. A width bit limits the comparison to the low 16 bits or uses all 32 bits. A compare event fires only on the first cycle in which the selected count equals a compare value. A sticky interrupt flag records completed events and stays set until a clear pulse arrives. The pin and the flag change on the clock edge at which the matching count is presented.

Top module: `ocmp_channel`

## Requirements
- R1: After synchronous reset, `pin_out` is 0, `irq_flag` is 0 and the channel is in mode 000.
- R2: Mode 001 (one-shot high): the write drives `pin_out` to 0. The first primary match after that drives it to 1 and sets `irq_flag`. Later matches have no effect until the mode is written again.
- R3: Mode 010 (one-shot low): the write drives `pin_out` to 1. The first primary match after that drives it to 0 and sets `irq_flag`. Later matches have no effect until the mode is written again.
- R4: Mode 011 (toggle): the write leaves `pin_out` unchanged. Each primary match inverts `pin_out` and sets `irq_flag`.
- R5: Mode 100 (single pulse): the write drives `pin_out` to 0. A primary match drives it to 1, and a later secondary match drives it back to 0. After that trailing edge no further pulse is produced until the mode is written again.
- R6: In mode 100, `irq_flag` is set by the trailing-edge (secondary) match and not by the leading-edge (primary) match.
- R7: A compare event fires only on the first cycle of equality. A count that stays on the compare value for several cycles produces exactly one event.
- R8: With `wide_mode`=0, only bits 15:0 of the timer and of the compare values are compared. With `wide_mode`=1, all 32 bits are compared.
- R9: `tmr_sel`=0 compares `tmr_a` and `tmr_sel`=1 compares `tmr_b`. The count that is not selected has no effect.
- R10: Writing the mode again re-arms a single change or single pulse while the timer keeps running.
- R11: Mode 000 and the unused codes 101, 110 and 111 hold `pin_out` at 0 and never set `irq_flag`.
- R12: `irq_flag` stays set until `irq_clr` is pulsed. If an event and `irq_clr` occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_a | input | 32 | Timer count source 0 |
| tmr_b | input | 32 | Timer count source 1 |
| tmr_sel | input | 1 | Selects the compared count (0: tmr_a, 1: tmr_b) |
| wide_mode | input | 1 | 1: 32-bit compare, 0: 16-bit compare |
| cfg_we | input | 1 | Mode write strobe |
| cfg_mode | input | 3 | Mode code written when cfg_we is 1 |
| cmp_pri | input | 32 | Primary compare value |
| cmp_sec | input | 32 | Secondary compare value (pulse trailing edge) |
| irq_clr | input | 1 | Clears the interrupt flag |
| pin_out | output | 1 | Output pin level |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench holds the count on the compare value for several cycles. A design that fires on level rather than on the first cycle of equality would toggle repeatedly, or would re-fire a one-shot. It replays the primary match after a pulse has ended, where a design that does not go idle would start a second pulse. It checks the flag on the leading edge of the pulse, where a wrongly placed flag would appear one edge early. In 16-bit mode it sets upper bits that differ, which catches full-width comparison, and it keeps a matching count on the bus that is not selected, which catches a swapped select. It also checks that an event wins over a clear in the same cycle, and that a rewrite re-arms the channel while the timer stays mid-count.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam int TMR_W    = 32;
    localparam int NARROW_W = 16;

    typedef enum logic [2:0] {
        OC_OFF    = 3'b000,
        OC_SET_HI = 3'b001,
        OC_SET_LO = 3'b010,
        OC_FLIP   = 3'b011,
        OC_PULSE  = 3'b100
    } oc_mode_e;

    // Channel state carried by the pin controller
    typedef struct packed {
        logic [2:0] mode;
        logic       pin;
        logic       armed;  // one-shot still pending
        logic       high;   // pulse leading edge already driven
        logic       flag;
    } oc_state_t;

    // Keep only the bits that take part in the comparison
    function automatic logic [TMR_W-1:0] cmp_mask(input logic wide,
                                                  input logic [TMR_W-1:0] v);
        logic [TMR_W-1:0] m;
        m = wide ? {TMR_W{1'b1}} : {{(TMR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        return v & m;
    endfunction

    // Level the pin takes on a mode write
    function automatic logic init_level(input logic [2:0] code, input logic cur);
        logic r;
        case (code)
            OC_SET_LO: r = 1'b1;
            OC_FLIP:   r = cur;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ocmp_match.sv
module ocmp_match
    import ocmp_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wide,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp_val,
    output logic         evt
);
    logic eq_now;
    logic eq_prev;

    assign eq_now = (cmp_mask(wide, count) == cmp_mask(wide, cmp_val));

    always_ff @(posedge clk) begin
        if (rst) eq_prev <= 1'b0;
        else     eq_prev <= eq_now;
    end

    // Only the first cycle of equality counts as an event
    assign evt = eq_now & ~eq_prev;
endmodule

// File: rtl/ocmp_pin_ctrl.sv
module ocmp_pin_ctrl
    import ocmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [2:0] cfg_mode,
    input  logic       pri_evt,
    input  logic       sec_evt,
    input  logic       irq_clr,
    output logic [2:0] cur_mode,
    output logic       pin,
    output logic       flag
);
    oc_state_t st_q, st_d;
    logic      set_flag;

    always_comb begin
        st_d     = st_q;
        set_flag = 1'b0;
        if (cfg_we) begin
            st_d.mode  = cfg_mode;
            st_d.pin   = init_level(cfg_mode, st_q.pin);
            st_d.armed = 1'b1;
            st_d.high  = 1'b0;
        end else begin
            case (st_q.mode)
                OC_SET_HI: if (st_q.armed && pri_evt) begin
                    st_d.pin   = 1'b1;
                    st_d.armed = 1'b0;
                    set_flag   = 1'b1;
                end
                OC_SET_LO: if (st_q.armed && pri_evt) begin
                    st_d.pin   = 1'b0;
                    st_d.armed = 1'b0;
                    set_flag   = 1'b1;
                end
                OC_FLIP: if (pri_evt) begin
                    st_d.pin = ~st_q.pin;
                    set_flag = 1'b1;
                end
                OC_PULSE: if (st_q.armed) begin
                    if (!st_q.high && pri_evt) begin
                        st_d.pin  = 1'b1;
                        st_d.high = 1'b1;
                    end else if (st_q.high && sec_evt) begin
                        st_d.pin   = 1'b0;
                        st_d.high  = 1'b0;
                        st_d.armed = 1'b0;
                        set_flag   = 1'b1;
                    end
                end
                default: st_d.pin = 1'b0;
            endcase
        end
        if (set_flag)     st_d.flag = 1'b1;
        else if (irq_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{mode: OC_OFF, pin: 1'b0, armed: 1'b0, high: 1'b0, flag: 1'b0};
        else     st_q <= st_d;
    end

    assign cur_mode = st_q.mode;
    assign pin      = st_q.pin;
    assign flag     = st_q.flag;
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tmr_a,
    input  logic [W-1:0] tmr_b,
    input  logic         tmr_sel,
    input  logic         wide_mode,
    input  logic         cfg_we,
    input  logic [2:0]   cfg_mode,
    input  logic [W-1:0] cmp_pri,
    input  logic [W-1:0] cmp_sec,
    input  logic         irq_clr,
    output logic         pin_out,
    output logic         irq_flag
);
    localparam int NCMP = 2;

    logic [W-1:0] count_sel;
    logic [W-1:0] cmp_arr [NCMP];
    logic [NCMP-1:0] evt_v;
    logic [2:0]   cur_mode;

    assign count_sel  = tmr_sel ? tmr_b : tmr_a;
    assign cmp_arr[0] = cmp_pri;
    assign cmp_arr[1] = cmp_sec;

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        ocmp_match #(.W(W)) u_match (
            .clk     (clk),
            .rst     (rst),
            .wide    (wide_mode),
            .count   (count_sel),
            .cmp_val (cmp_arr[i]),
            .evt     (evt_v[i])
        );
    end

    ocmp_pin_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_mode (cfg_mode),
        .pri_evt  (evt_v[0]),
        .sec_evt  (evt_v[1]),
        .irq_clr  (irq_clr),
        .cur_mode (cur_mode),
        .pin      (pin_out),
        .flag     (irq_flag)
    );
endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [2:0] cfg_mode,
    input logic [2:0] cur_mode,
    input logic       pri_evt,
    input logic       sec_evt,
    input logic       irq_clr,
    input logic       pin_out,
    input logic       irq_flag
);
    // R2 R5
    low_init_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_mode == 3'b001 || cfg_mode == 3'b100)) |=> !pin_out);

    // R3
    high_init_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_mode == 3'b010) |=> pin_out);

    // R4
    toggle_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_mode == 3'b011) |=> $stable(pin_out));

    // R11
    off_low_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 3'b000 || cur_mode > 3'b100) |-> !pin_out);

    // R7
    single_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (pri_evt || sec_evt) |=> !($past(pri_evt) && pri_evt) && !($past(sec_evt) && sec_evt));

    // R12
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R12
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> $past(pri_evt || sec_evt));
endmodule

bind ocmp_channel ocmp_channel_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_mode (cfg_mode),
    .cur_mode (cur_mode),
    .pri_evt  (evt_v[0]),
    .sec_evt  (evt_v[1]),
    .irq_clr  (irq_clr),
    .pin_out  (pin_out),
    .irq_flag (irq_flag)
);

// File: tb/ocmp_channel_tb.sv
module ocmp_channel_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] tmr_a, tmr_b, cmp_pri, cmp_sec;
    logic        tmr_sel, wide_mode, cfg_we, irq_clr;
    logic [2:0]  cfg_mode;
    logic        pin_out, irq_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    ocmp_channel u_dut (
        .clk(clk), .rst(rst), .tmr_a(tmr_a), .tmr_b(tmr_b), .tmr_sel(tmr_sel),
        .wide_mode(wide_mode), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cmp_pri(cmp_pri), .cmp_sec(cmp_sec), .irq_clr(irq_clr),
        .pin_out(pin_out), .irq_flag(irq_flag)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  mode;
        logic [31:0] tmr;
        logic        clr;
        logic        pin;
        logic        flag;
    } vec_t;

    // primary compare 100, secondary 200, 32-bit, tmr_a selected
    localparam int NV = 19;
    localparam vec_t VT [NV] = '{
        '{1'b1, 3'd1, 32'd0,   1'b0, 1'b0, 1'b0},  // R2 write: low
        '{1'b0, 3'd0, 32'd100, 1'b0, 1'b1, 1'b1},  // R2 match: high
        '{1'b0, 3'd0, 32'd0,   1'b0, 1'b1, 1'b1},
        '{1'b0, 3'd0, 32'd100, 1'b0, 1'b1, 1'b1},  // R2 no retrigger
        '{1'b1, 3'd2, 32'd0,   1'b1, 1'b1, 1'b0},  // R3 write: high
        '{1'b0, 3'd0, 32'd100, 1'b0, 1'b0, 1'b1},  // R3 match: low
        '{1'b1, 3'd3, 32'd0,   1'b1, 1'b0, 1'b0},  // R4 write keeps level
        '{1'b0, 3'd0, 32'd100, 1'b0, 1'b1, 1'b1},  // R4 toggle
        '{1'b0, 3'd0, 32'd50,  1'b1, 1'b1, 1'b0},
        '{1'b0, 3'd0, 32'd100, 1'b0, 1'b0, 1'b1},  // R4 toggle back
        '{1'b1, 3'd4, 32'd0,   1'b1, 1'b0, 1'b0},  // R5 write: low
        '{1'b0, 3'd0, 32'd100, 1'b0, 1'b1, 1'b0},  // R6 no flag on leading edge
        '{1'b0, 3'd0, 32'd150, 1'b0, 1'b1, 1'b0},
        '{1'b0, 3'd0, 32'd200, 1'b0, 1'b0, 1'b1},  // R5 R6 trailing edge
        '{1'b0, 3'd0, 32'd100, 1'b0, 1'b0, 1'b1},  // R5 no second pulse
        '{1'b0, 3'd0, 32'd200, 1'b0, 1'b0, 1'b1},
        '{1'b1, 3'd4, 32'd150, 1'b1, 1'b0, 1'b0},  // R10 rearm mid-count
        '{1'b0, 3'd0, 32'd100, 1'b0, 1'b1, 1'b0},  // R10 leading
        '{1'b0, 3'd0, 32'd200, 1'b0, 1'b0, 1'b1}   // R10 trailing
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Apply inputs after a falling edge, let one rising edge pass, sample at next falling edge
    task automatic step(input logic we, input logic [2:0] m, input logic [31:0] ta,
                        input logic clr);
        cfg_we = we; cfg_mode = m; tmr_a = ta; irq_clr = clr;
        @(negedge clk);
        cfg_we = 1'b0; irq_clr = 1'b0;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; tmr_a = 0; tmr_b = 0; tmr_sel = 0; wide_mode = 1;
        cfg_we = 0; cfg_mode = 0; irq_clr = 0; cmp_pri = 100; cmp_sec = 200;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 pin", pin_out, 1'b0);
        check("R1 flag", irq_flag, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VT[i].we, VT[i].mode, VT[i].tmr, VT[i].clr);
            check($sformatf("table[%0d] pin", i), pin_out, VT[i].pin);
            check($sformatf("table[%0d] flag", i), irq_flag, VT[i].flag);
        end

        // R7 stalled count: one toggle only
        step(1'b1, 3'd3, 32'd0, 1'b1);
        step(1'b0, 3'd0, 32'd100, 1'b0);
        check("R7 first toggle", pin_out, 1'b1);
        step(1'b0, 3'd0, 32'd100, 1'b0);
        step(1'b0, 3'd0, 32'd100, 1'b0);
        check("R7 stalled no retoggle", pin_out, 1'b1);

        // R8 narrow compare ignores upper bits
        cmp_pri = 32'h0001_0064;
        wide_mode = 1'b1;
        step(1'b1, 3'd1, 32'd0, 1'b1);
        step(1'b0, 3'd0, 32'h0000_0064, 1'b0);
        check("R8 wide mismatch", pin_out, 1'b0);
        step(1'b0, 3'd0, 32'd0, 1'b0);
        wide_mode = 1'b0;
        step(1'b0, 3'd0, 32'h0000_0064, 1'b0);
        check("R8 narrow match", pin_out, 1'b1);
        wide_mode = 1'b1;
        cmp_pri = 100;

        // R9 timer select
        tmr_sel = 1'b1; tmr_b = 0;
        step(1'b1, 3'd1, 32'd0, 1'b1);
        step(1'b0, 3'd0, 32'd100, 1'b0);
        check("R9 unselected ignored", pin_out, 1'b0);
        tmr_b = 100;
        step(1'b0, 3'd0, 32'd100, 1'b0);
        check("R9 selected match", pin_out, 1'b1);
        tmr_sel = 1'b0; tmr_b = 0;

        // R11 off and unused codes
        step(1'b1, 3'd0, 32'd0, 1'b1);
        check("R11 off forces low", pin_out, 1'b0);
        step(1'b0, 3'd0, 32'd100, 1'b0);
        check("R11 off pin", pin_out, 1'b0);
        check("R11 off flag", irq_flag, 1'b0);
        step(1'b1, 3'd6, 32'd0, 1'b0);
        step(1'b0, 3'd0, 32'd100, 1'b0);
        check("R11 unused pin", pin_out, 1'b0);
        check("R11 unused flag", irq_flag, 1'b0);

        // R12 sticky flag, event beats clear
        step(1'b1, 3'd3, 32'd0, 1'b0);
        step(1'b0, 3'd0, 32'd100, 1'b0);
        step(1'b0, 3'd0, 32'd0, 1'b0);
        step(1'b0, 3'd0, 32'd0, 1'b0);
        check("R12 sticky", irq_flag, 1'b1);
        step(1'b0, 3'd0, 32'd0, 1'b1);
        check("R12 clear", irq_flag, 1'b0);
        step(1'b0, 3'd0, 32'd100, 1'b1);
        check("R12 set wins over clear", irq_flag, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule